// File: doc/BRIEF.md
# Coarse-Fine Delay-Line Lock Controller

This block sets the control code of a digitally tuned delay line so that the line's tenth tap trails its input by one full reference period. That tap is the edge that a replica line's tenth phase is aligned to. Locking happens in two phases. In the coarse phase the controller waits a settle window and then samples a 5-bit thermometer result from a time-to-digital converter. It turns that result into a 3-bit coarse code. In the fine phase it runs a 4-bit binary successive-approximation search, one trial bit per settle window, steered by a single early/late comparison bit.

Once the last trial bit is resolved the controller raises its lock flag and freezes the code until a synchronous restart pulse arrives. A separate 3-bit duty setting picks which of the ten equally spaced line phases feeds the output latch. This gives output duty cycles of 30 % to 70 %.

The FSM has three states. `ST_COARSE` waits for the settle timer, then loads the coarse code and moves to `ST_FINE`. `ST_FINE` resolves one trial bit each time the settle timer expires, and moves to `ST_LOCK` after the least significant bit. `ST_LOCK` holds. A `restart` pulse takes any state back to `ST_COARSE`.

Top module: `dline_lock_ctrl`

## Requirements
- R1: While `rst_n` is low the controller is in `ST_COARSE`, `locked` is 0, and `dl_code` is at mid-scale: coarse field (bits 6:4) = 2 and fine field (bits 3:0) = 4'b1000.
- R2: `SETTLE_CYC` (default 4) clock edges after the coarse phase is entered, the coarse field is loaded with the number of consecutive ones in `tdc_therm`, counted from bit 0 upward (range 0 to 5).
- R3: A bubble pattern in `tdc_therm` is resolved at the first zero counted from bit 0. For example, 5'b01011 gives 2 and 5'b11110 gives 0.
- R4: The fine search tests bits 3, 2, 1 and 0 in that order, starting from trial 4'b1000. When `early_late` is 1 (late) at the sampling edge, the trial bit is cleared. When it is 0 the bit is kept, and the next lower bit is set as the new trial.
- R5: Each fine bit is sampled after a settle window of `SETTLE_CYC` edges. `locked` rises exactly `SETTLE_CYC*5` (default 20) edges after the edge that entered the coarse phase.
- R6: While locked, `dl_code` and `locked` are unchanged whatever `tdc_therm` and `early_late` do, until `restart` is pulsed.
- R7: A `restart` high at a clock edge returns the controller to `ST_COARSE`, with `locked` at 0 and `dl_code` at mid-scale after that edge.
- R8: `tap_sel` = 3 + `duty_sel` for `duty_sel` 0 to 4, i.e. taps 3 to 7 for 30 % to 70 %. Any `duty_sel` above 4 gives tap 7. `tap_sel` follows `duty_sel` combinationally in every state.
- R9: During the coarse settle window the fine field stays at 4'b1000 and the coarse field stays at mid-scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous relock request |
| tdc_therm | input | 5 | Thermometer code from the time-to-digital converter |
| early_late | input | 1 | Phase comparison, 1 = delay line late |
| duty_sel | input | 3 | Duty-cycle setting, 0 = 30 % ... 4 = 70 % |
| dl_code | output | 7 | Delay-line control code {coarse[2:0], fine[3:0]} |
| locked | output | 1 | Lock flag |
| tap_sel | output | 4 | Index of the delay-line phase used for the falling edge |

## Verification
The hardest conditions to reach are those where the coarse code and the phase target disagree. In those cases the fine search must pin at 0 or 15, or the thermometer carries a bubble. A correct design gives the same trial sequence for many of these inputs, so a plain early/late pattern cannot tell it apart from a faulty one. The bench therefore uses a behavioural delay-line model that reports late whenever the present code exceeds a chosen target. This lets it place targets below, inside and above the coarse step, with each relock started by `restart`. While locked, a forced early/late toggle and an inverted thermometer drive the controller, to show that both are ignored.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        ST_COARSE = 2'd0,
        ST_FINE   = 2'd1,
        ST_LOCK   = 2'd2
    } dlc_state_e;
endpackage

// File: rtl/dlc_therm2bin.sv
module dlc_therm2bin #(
    parameter int TDC_W = 5,
    localparam int CRS_W = $clog2(TDC_W + 1)
) (
    input  logic [TDC_W-1:0] therm,
    output logic [CRS_W-1:0] bin
);
    logic stop;
    always_comb begin
        bin  = '0;
        stop = 1'b0;
        for (int i = 0; i < TDC_W; i++) begin
            if (!stop && therm[i]) bin = CRS_W'(i + 1);
            else                   stop = 1'b1;
        end
    end
endmodule

// File: rtl/dlc_settle_timer.sv
module dlc_settle_timer #(
    parameter int SETTLE_CYC = 4,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == CNT_W'(SETTLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (done)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dlc_tap_map.sv
module dlc_tap_map #(
    parameter int NUM_TAPS   = 10,
    parameter int TAP_LO     = 3,
    parameter int DUTY_STEPS = 5,
    parameter int DUTY_W     = 3,
    localparam int TAP_W = $clog2(NUM_TAPS)
) (
    input  logic [DUTY_W-1:0] duty,
    output logic [TAP_W-1:0]  tap
);
    localparam int TAP_HI = TAP_LO + DUTY_STEPS - 1;

    always_comb begin
        if (duty >= DUTY_W'(DUTY_STEPS)) tap = TAP_W'(TAP_HI);
        else                             tap = TAP_W'(TAP_LO) + TAP_W'(duty);
    end
endmodule

// File: rtl/dline_lock_ctrl.sv
module dline_lock_ctrl #(
    parameter int TDC_W      = 5,
    parameter int FINE_W     = 4,
    parameter int SETTLE_CYC = 4,
    parameter int NUM_TAPS   = 10,
    parameter int TAP_LO     = 3,
    parameter int DUTY_STEPS = 5,
    parameter int DUTY_W     = 3,
    localparam int CRS_W  = $clog2(TDC_W + 1),
    localparam int CODE_W = CRS_W + FINE_W,
    localparam int TAP_W  = $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [TDC_W-1:0]  tdc_therm,
    input  logic              early_late,
    input  logic [DUTY_W-1:0] duty_sel,
    output logic [CODE_W-1:0] dl_code,
    output logic              locked,
    output logic [TAP_W-1:0]  tap_sel
);
    import dlc_pkg::*;

    localparam int BIT_W = (FINE_W > 1) ? $clog2(FINE_W) : 1;
    localparam logic [CRS_W-1:0]  MID_C = CRS_W'(TDC_W / 2);
    localparam logic [FINE_W-1:0] MID_F = FINE_W'(1) << (FINE_W - 1);

    dlc_state_e        state_q, state_d;
    logic [CRS_W-1:0]  coarse_q;
    logic [FINE_W-1:0] fine_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CRS_W-1:0]  therm_bin;
    logic              tmr_done;
    logic              tmr_clr;

    dlc_therm2bin #(.TDC_W(TDC_W)) u_t2b (
        .therm (tdc_therm),
        .bin   (therm_bin)
    );

    assign tmr_clr = restart || (state_q == ST_LOCK);

    dlc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .done  (tmr_done)
    );

    dlc_tap_map #(
        .NUM_TAPS   (NUM_TAPS),
        .TAP_LO     (TAP_LO),
        .DUTY_STEPS (DUTY_STEPS),
        .DUTY_W     (DUTY_W)
    ) u_tap (
        .duty (duty_sel),
        .tap  (tap_sel)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COARSE: if (tmr_done) state_d = ST_FINE;
            ST_FINE:   if (tmr_done && bit_q == '0) state_d = ST_LOCK;
            ST_LOCK:   state_d = ST_LOCK;
            default:   state_d = ST_COARSE;
        endcase
        if (restart) state_d = ST_COARSE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COARSE;
        else        state_q <= state_d;
    end

    // code registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q <= MID_C;
            fine_q   <= MID_F;
            bit_q    <= BIT_W'(FINE_W - 1);
        end else if (restart) begin
            coarse_q <= MID_C;
            fine_q   <= MID_F;
            bit_q    <= BIT_W'(FINE_W - 1);
        end else begin
            unique case (state_q)
                ST_COARSE: if (tmr_done) coarse_q <= therm_bin;
                ST_FINE: begin
                    if (tmr_done) begin
                        if (early_late) fine_q[bit_q] <= 1'b0;
                        if (bit_q != '0) begin
                            fine_q[bit_q - 1'b1] <= 1'b1;
                            bit_q                <= bit_q - 1'b1;
                        end
                    end
                end
                ST_LOCK: ;
                default: ;
            endcase
        end
    end

    assign dl_code = {coarse_q, fine_q};
    assign locked  = (state_q == ST_LOCK);
endmodule

// File: rtl/dline_lock_chk.sv
module dline_lock_chk #(
    parameter int TDC_W      = 5,
    parameter int FINE_W     = 4,
    parameter int NUM_TAPS   = 10,
    parameter int TAP_LO     = 3,
    parameter int DUTY_STEPS = 5,
    parameter int DUTY_W     = 3,
    localparam int CRS_W  = $clog2(TDC_W + 1),
    localparam int CODE_W = CRS_W + FINE_W,
    localparam int TAP_W  = $clog2(NUM_TAPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic [DUTY_W-1:0] duty_sel,
    input logic [CODE_W-1:0] dl_code,
    input logic              locked,
    input logic [TAP_W-1:0]  tap_sel
);
    localparam logic [CODE_W-1:0] MID =
        {CRS_W'(TDC_W / 2), FINE_W'(1) << (FINE_W - 1)};
    localparam int TAP_HI = TAP_LO + DUTY_STEPS - 1;

    logic [FINE_W-1:0] fine;
    logic [CRS_W-1:0]  coarse;
    assign fine   = dl_code[FINE_W-1:0];
    assign coarse = dl_code[CODE_W-1:FINE_W];

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_MID: assert (dl_code == MID && !locked); // R1
        end
    end

    AST_COARSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        coarse <= CRS_W'(TDC_W)); // R2

    AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !restart) |=> ($countones(fine ^ $past(fine)) <= 2)); // R4

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> (locked && $stable(dl_code))); // R6

    AST_RESTART_MID: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!locked && dl_code == MID)); // R7

    AST_TAP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel >= DUTY_W'(DUTY_STEPS)) |-> (tap_sel == TAP_W'(TAP_HI))); // R8

    AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel >= TAP_W'(TAP_LO) && tap_sel <= TAP_W'(TAP_HI))); // R8
endmodule

bind dline_lock_ctrl dline_lock_chk #(
    .TDC_W      (TDC_W),
    .FINE_W     (FINE_W),
    .NUM_TAPS   (NUM_TAPS),
    .TAP_LO     (TAP_LO),
    .DUTY_STEPS (DUTY_STEPS),
    .DUTY_W     (DUTY_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .duty_sel (duty_sel),
    .dl_code  (dl_code),
    .locked   (locked),
    .tap_sel  (tap_sel)
);

// File: tb/sim_dline_lock_ctrl.sv
module sim_dline_lock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK_CYC   = 20;

    typedef struct {
        logic [6:0] code;
        logic [3:0] tap;
        int         cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       restart = 1'b0;
    logic [4:0] tdc_therm = '0;
    logic       early_late;
    logic [2:0] duty_sel = '0;
    logic [6:0] dl_code;
    logic       locked;
    logic [3:0] tap_sel;

    logic [6:0] target = '0;
    logic       force_en = 1'b0;
    logic       force_val = 1'b0;
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;
    logic       lock_d = 1'b0;
    exp_t       exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural delay line + phase detector: late when code exceeds target
    assign early_late = force_en ? force_val : (dl_code > target);

    dline_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tdc_therm(tdc_therm),
        .early_late(early_late), .duty_sel(duty_sel), .dl_code(dl_code),
        .locked(locked), .tap_sel(tap_sel)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // monitor: compare each lock event with the scoreboard head
    always @(negedge clk) begin
        lock_d <= locked;
        if (rst_n && locked && !lock_d) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected lock", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R4 locked code", int'(dl_code), int'(e.code));
                chk("R8 tap at lock", int'(tap_sel), int'(e.tap));
                chk("R5 lock cycle", cyc, e.cyc);
            end
        end
    end

    // driver: start a relock and push the expected result
    task automatic run_case(input logic [4:0] th, input logic [6:0] tgt,
                            input logic [2:0] duty, input logic [2:0] c_exp,
                            input logic [3:0] f_exp, input logic [3:0] t_exp);
        exp_t e;
        int   n;
        @(negedge clk);
        tdc_therm = th; target = tgt; duty_sel = duty; force_en = 1'b0;
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        n = cyc;
        e.code = {c_exp, f_exp}; e.tap = t_exp; e.cyc = n + LOCK_CYC;
        exp_q.push_back(e);
        chk("R7 restart mid code", int'(dl_code), 7'h28);
        chk("R7 restart unlock", int'(locked), 0);
        repeat (2) @(negedge clk);
        chk("R9 coarse window code", int'(dl_code), 7'h28);
        repeat (2) @(negedge clk);
        chk("R2 R3 coarse field", int'(dl_code[6:4]), int'(c_exp));
        chk("R4 first trial", int'(dl_code[3:0]), 8);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        exp_t e;
        logic [6:0] held;
        #1 rst_n = 1'b0;
        tdc_therm = 5'b00111; target = 7'd57; duty_sel = 3'd2;
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(dl_code), 7'h28);
        chk("R1 reset lock", int'(locked), 0);
        e.code = {3'd3, 4'd9}; e.tap = 4'd5; e.cyc = LOCK_CYC;
        exp_q.push_back(e);
        rst_n = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);

        // R6: hold while locked under changing inputs
        held = dl_code;
        force_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            force_val = ~force_val;
            tdc_therm = ~tdc_therm;
            @(negedge clk);
        end
        chk("R6 held code", int'(dl_code), int'(held));
        chk("R6 held lock", int'(locked), 1);
        force_en = 1'b0;

        run_case(5'b01011, 7'd40,  3'd0, 3'd2, 4'd8,  4'd3);  // R3 bubble
        run_case(5'b11111, 7'd100, 3'd7, 3'd5, 4'd15, 4'd7);  // R4 pin high, R8 clamp
        run_case(5'b00000, 7'd0,   3'd4, 3'd0, 4'd0,  4'd7);  // R4 pin low
        run_case(5'b11110, 7'd5,   3'd5, 3'd0, 4'd5,  4'd7);  // R3 bit0 zero
        run_case(5'b00011, 7'd38,  3'd1, 3'd2, 4'd6,  4'd4);  // R4 mixed

        // R8: combinational tap map over all settings
        for (int d = 0; d < 8; d++) begin
            duty_sel = 3'(d);
            #1;
            chk("R8 tap map", int'(tap_sel), (d > 4) ? 7 : 3 + d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule